// File: doc/BRIEF.md
# Floating-Point Exception Mask Controller

This block sits beside a floating-point datapath and manages the six exception conditions that an operation can report: invalid operation, denormal operand, zero divide, overflow, underflow and precision loss. Each completed operation presents its exception bits with a valid strobe. The block accumulates them into sticky status flags. It compares them against a mask field in a writable control word. For a masked condition it tells the datapath, in the same cycle, to substitute a default result (for example infinity on zero divide), so that execution simply continues.

An unmasked condition does not interrupt the host at once. It sets a summary bit in the status word and waits. The host and the floating-point unit run concurrently, and the host learns of the problem only when it issues a wait request. If the summary bit is set at that point, the block raises an interrupt request and withholds the wait acknowledge until software clears the flags or masks the condition again.

Top module: `fpx_exc_ctrl`

## Requirements
- R1: After reset the control word reads 0x003F (every condition masked), the status word reads 0x0000, `irq` is low and `def_sel` is zero.
- R2: Exception bit positions are 0 invalid, 1 denormal, 2 zero divide, 3 overflow, 4 underflow and 5 precision, in `exc_bits`, in the status flags and in the control mask alike. When `exc_vld` is high, each set bit of `exc_bits` sets its status flag from the next cycle on. Flags accumulate by OR and are not cleared by later operations.
- R3: When `exc_vld` is low, `exc_bits` has no effect on the flags or on `def_sel`.
- R4: In the cycle that `exc_vld` is high, `def_sel[i]` is high exactly when `exc_bits[i]` is set and mask bit i is set. An unmasked condition never selects a default result.
- R5: Status bit 7 reads 1 exactly when some flag is set whose mask bit is clear. Status bit 6 and bits 8 to 15 read 0.
- R6: A cycle with `ctl_wr` high loads `ctl_wdata[5:0]` into the mask from the next cycle on, and the upper control bits read 0. Clearing bit 2 unmasks zero divide.
- R7: While no wait request is made, an unmasked exception does not raise `irq`.
- R8: When `wait_req` is high while status bit 7 is set, `wait_done` stays low and `irq` is high from the next cycle until status bit 7 clears.
- R9: When `wait_req` is high while status bit 7 is clear, `wait_done` is high in that same cycle.
- R10: A cycle with `flag_clr` high zeroes the flags from the next cycle on. An exception that is valid in the same cycle still leaves its own flags set. `irq` falls in the cycle after status bit 7 becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_vld | input | 1 | Operation completion strobe qualifying `exc_bits` |
| exc_bits | input | 6 | Exception conditions raised by the completing operation |
| ctl_wr | input | 1 | Control word write enable |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word read value |
| sts_rdata | output | 16 | Status word: sticky flags and summary bit |
| flag_clr | input | 1 | Clear all sticky flags |
| wait_req | input | 1 | Host synchronize request |
| wait_done | output | 1 | Synchronize acknowledge |
| irq | output | 1 | Interrupt request for an unmasked pending exception |
| def_sel | output | 6 | Per-condition default-result select to the datapath |

## Verification
Two events can fall in the same cycle here. A flag clear can coincide with a freshly reported exception, and a wait request can coincide with the clear that retires the pending summary. The bench drives both combinations in single table rows. It asserts `flag_clr`, `exc_vld` and `wait_req` together while an unmasked flag is pending. It then checks that the new masked flag survives the clear, that `wait_done` stays low in that cycle, and that `irq` holds for exactly one more cycle before it falls. These expectations come from the OR-after-clear rule and from a summary taken from the registered flags.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   // condition indices; the mask and the flags share this bit order
   typedef enum int unsigned {
      FPX_INV  = 0,
      FPX_DEN  = 1,
      FPX_ZDIV = 2,
      FPX_OVF  = 3,
      FPX_UNF  = 4,
      FPX_PREC = 5
   } fpx_cond_e;

   localparam int unsigned FPX_NCOND   = 6;
   localparam int unsigned FPX_WORD_W  = 16;
   localparam int unsigned FPX_SUM_POS = 7;
endpackage

// File: rtl/fpx_mask_reg.sv
module fpx_mask_reg #(
   parameter int unsigned NCOND = 6,
   parameter int unsigned CW_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CW_W-1:0]  wdata,
   output logic [NCOND-1:0] mask,
   output logic [CW_W-1:0]  rdata
);
   localparam int unsigned HI_W = CW_W - NCOND;

   if (NCOND == 0 || NCOND >= CW_W) begin : g_bad_width
      $error("fpx_mask_reg: NCOND must be between 1 and CW_W-1");
   end

   logic [NCOND-1:0] mask_q;
   logic             unused_wdata_hi;

   assign unused_wdata_hi = ^wdata[CW_W-1:NCOND];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q <= '1;
      else if (wr) mask_q <= wdata[NCOND-1:0];
   end

   assign mask  = mask_q;
   assign rdata = {{HI_W{1'b0}}, mask_q};

   // R6
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(mask));

   // R6
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (mask == $past(wdata[NCOND-1:0])));
endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank #(
   parameter int unsigned NCOND    = 6,
   parameter bit          CLR_WINS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc_vld,
   input  logic [NCOND-1:0] exc_bits,
   input  logic             clr,
   output logic [NCOND-1:0] flags
);
   logic [NCOND-1:0] flag_q;
   logic [NCOND-1:0] hit;

   assign hit = exc_vld ? exc_bits : '0;

   for (genvar i = 0; i < NCOND; i++) begin : g_flag
      logic nxt;
      if (CLR_WINS) begin : g_clr_first
         assign nxt = clr ? 1'b0 : (flag_q[i] | hit[i]);
      end else begin : g_new_survives
         assign nxt = (flag_q[i] & ~clr) | hit[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= nxt;
      end

      // R2
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !clr) |=> flags[i]);

      // R3
      flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!flags[i] && !exc_vld) |=> !flags[i]);
   end

   assign flags = flag_q;

   // R10
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !exc_vld) |=> (flags == '0));
endmodule

// File: rtl/fpx_defsel.sv
module fpx_defsel #(
   parameter int unsigned NCOND      = 6,
   parameter bit          REG_DEFSEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc_vld,
   input  logic [NCOND-1:0] exc_bits,
   input  logic [NCOND-1:0] mask,
   output logic [NCOND-1:0] def_sel
);
   logic [NCOND-1:0] sel_c;

   assign sel_c = exc_vld ? (exc_bits & mask) : '0;

   if (REG_DEFSEL) begin : g_reg
      logic [NCOND-1:0] sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sel_q <= '0;
         else        sel_q <= sel_c;
      end
      assign def_sel = sel_q;
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign def_sel = sel_c;
   end
endmodule

// File: rtl/fpx_sync.sv
module fpx_sync #(
   parameter int unsigned NCOND = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCOND-1:0] flags,
   input  logic [NCOND-1:0] mask,
   input  logic             wait_req,
   output logic             summary,
   output logic             wait_done,
   output logic             irq
);
   logic irq_q;

   assign summary   = |(flags & ~mask);
   assign wait_done = wait_req & ~summary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= summary & (irq_q | wait_req);
   end

   assign irq = irq_q;

   // R7
   irq_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wait_req && !irq) |=> !irq);

   // R8
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && summary) |=> irq);

   // R10
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !summary |=> !irq);
endmodule

// File: rtl/fpx_exc_ctrl.sv
module fpx_exc_ctrl #(
   parameter int unsigned NCOND      = fpx_pkg::FPX_NCOND,
   parameter int unsigned CW_W       = fpx_pkg::FPX_WORD_W,
   parameter int unsigned SW_W       = fpx_pkg::FPX_WORD_W,
   parameter int unsigned SUM_POS    = fpx_pkg::FPX_SUM_POS,
   parameter bit          CLR_WINS   = 1'b0,
   parameter bit          REG_DEFSEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc_vld,
   input  logic [NCOND-1:0] exc_bits,
   input  logic             ctl_wr,
   input  logic [CW_W-1:0]  ctl_wdata,
   output logic [CW_W-1:0]  ctl_rdata,
   output logic [SW_W-1:0]  sts_rdata,
   input  logic             flag_clr,
   input  logic             wait_req,
   output logic             wait_done,
   output logic             irq,
   output logic [NCOND-1:0] def_sel
);
   if (SUM_POS < NCOND || SUM_POS >= SW_W) begin : g_bad_sum
      $error("fpx_exc_ctrl: SUM_POS must lie above the flags and inside the status word");
   end

   logic [NCOND-1:0] mask;
   logic [NCOND-1:0] flags;
   logic             summary;

   fpx_mask_reg #(.NCOND(NCOND), .CW_W(CW_W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctl_wr),
      .wdata (ctl_wdata),
      .mask  (mask),
      .rdata (ctl_rdata)
   );

   fpx_flag_bank #(.NCOND(NCOND), .CLR_WINS(CLR_WINS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .exc_vld  (exc_vld),
      .exc_bits (exc_bits),
      .clr      (flag_clr),
      .flags    (flags)
   );

   fpx_defsel #(.NCOND(NCOND), .REG_DEFSEL(REG_DEFSEL)) u_defsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .exc_vld  (exc_vld),
      .exc_bits (exc_bits),
      .mask     (mask),
      .def_sel  (def_sel)
   );

   fpx_sync #(.NCOND(NCOND)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags     (flags),
      .mask      (mask),
      .wait_req  (wait_req),
      .summary   (summary),
      .wait_done (wait_done),
      .irq       (irq)
   );

   // status word assembly: flags low, summary at SUM_POS, zero elsewhere
   for (genvar b = 0; b < SW_W; b++) begin : g_sts
      if (b < NCOND) begin : g_flag
         assign sts_rdata[b] = flags[b];
      end else if (b == SUM_POS) begin : g_sum
         assign sts_rdata[b] = summary;
      end else begin : g_zero
         assign sts_rdata[b] = 1'b0;
      end
   end

   // R4
   defsel_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((def_sel & ~mask) == '0) || REG_DEFSEL);

   // R9
   wait_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && !sts_rdata[SUM_POS]) |-> wait_done);

   // R8
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && sts_rdata[SUM_POS]) |-> !wait_done);
endmodule

// File: tb/fpx_exc_ctrl_tb.sv
`timescale 1ns/1ps
module fpx_exc_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_vld = 1'b0;
   logic [5:0]  exc_bits = '0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] ctl_rdata;
   logic [15:0] sts_rdata;
   logic        flag_clr = 1'b0;
   logic        wait_req = 1'b0;
   logic        wait_done;
   logic        irq;
   logic [5:0]  def_sel;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   fpx_exc_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .exc_vld(exc_vld), .exc_bits(exc_bits),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .sts_rdata(sts_rdata), .flag_clr(flag_clr), .wait_req(wait_req),
      .wait_done(wait_done), .irq(irq), .def_sel(def_sel)
   );

   typedef struct packed {
      logic        wr;
      logic [15:0] wdata;
      logic        vld;
      logic [5:0]  exc;
      logic        clr;
      logic        wt;
      logic [5:0]  e_sel;   // before the edge
      logic        e_wdone; // before the edge
      logic [15:0] e_sts;   // after the edge
      logic [15:0] e_ctl;   // after the edge
      logic        e_irq;   // after the edge
   } vec_t;

   localparam vec_t TBL [13] = '{
      // masked zero divide selects a default result (R4)
      '{1'b0, 16'h0000, 1'b1, 6'h04, 1'b0, 1'b0, 6'h04, 1'b0, 16'h0004, 16'h003F, 1'b0},
      // bits without the strobe are ignored (R3)
      '{1'b0, 16'h0000, 1'b0, 6'h3F, 1'b0, 1'b0, 6'h00, 1'b0, 16'h0004, 16'h003F, 1'b0},
      // invalid and precision accumulate (R2)
      '{1'b0, 16'h0000, 1'b1, 6'h21, 1'b0, 1'b0, 6'h21, 1'b0, 16'h0025, 16'h003F, 1'b0},
      // wait with nothing unmasked is acknowledged (R9)
      '{1'b0, 16'h0000, 1'b0, 6'h00, 1'b0, 1'b1, 6'h00, 1'b1, 16'h0025, 16'h003F, 1'b0},
      // unmask zero divide, upper write bits dropped (R6), summary appears (R5)
      '{1'b1, 16'hFF3B, 1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0, 16'h00A5, 16'h003B, 1'b0},
      // no wait, no interrupt (R7)
      '{1'b0, 16'h0000, 1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0, 16'h00A5, 16'h003B, 1'b0},
      // wait with summary set (R8)
      '{1'b0, 16'h0000, 1'b0, 6'h00, 1'b0, 1'b1, 6'h00, 1'b0, 16'h00A5, 16'h003B, 1'b1},
      '{1'b0, 16'h0000, 1'b0, 6'h00, 1'b0, 1'b1, 6'h00, 1'b0, 16'h00A5, 16'h003B, 1'b1},
      // clear, masked overflow and wait in one cycle (R10)
      '{1'b0, 16'h0000, 1'b1, 6'h08, 1'b1, 1'b1, 6'h08, 1'b0, 16'h0008, 16'h003B, 1'b1},
      // summary gone: wait acknowledged, irq falls (R9, R10)
      '{1'b0, 16'h0000, 1'b0, 6'h00, 1'b0, 1'b1, 6'h00, 1'b1, 16'h0008, 16'h003B, 1'b0},
      // unmasked zero divide gets no default result (R4)
      '{1'b0, 16'h0000, 1'b1, 6'h04, 1'b0, 1'b0, 6'h00, 1'b0, 16'h008C, 16'h003B, 1'b0},
      // re-mask drops summary (R5, R6)
      '{1'b1, 16'h003F, 1'b0, 6'h00, 1'b0, 1'b0, 6'h00, 1'b0, 16'h000C, 16'h003F, 1'b0},
      // plain clear (R10)
      '{1'b0, 16'h0000, 1'b0, 6'h00, 1'b1, 1'b0, 6'h00, 1'b0, 16'h0000, 16'h003F, 1'b0}
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v, input int idx);
      @(negedge clk);
      ctl_wr = v.wr; ctl_wdata = v.wdata; exc_vld = v.vld; exc_bits = v.exc;
      flag_clr = v.clr; wait_req = v.wt;
      #1;
      check($sformatf("R4 def_sel row %0d", idx), {10'd0, def_sel}, {10'd0, v.e_sel});
      check($sformatf("R8/R9 wait_done row %0d", idx), {15'd0, wait_done}, {15'd0, v.e_wdone});
      @(posedge clk);
      #1;
      ctl_wr = 1'b0; exc_vld = 1'b0; exc_bits = '0; flag_clr = 1'b0; wait_req = 1'b0;
      check($sformatf("R2/R5 status row %0d", idx), sts_rdata, v.e_sts);
      check($sformatf("R6 control row %0d", idx), ctl_rdata, v.e_ctl);
      check($sformatf("R7/R8 irq row %0d", idx), {15'd0, irq}, {15'd0, v.e_irq});
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 control", ctl_rdata, 16'h003F);
      check("R1 status", sts_rdata, 16'h0000);
      check("R1 irq", {15'd0, irq}, 16'h0000);
      check("R1 def_sel", {10'd0, def_sel}, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < 13; i++) apply(TBL[i], i);

      // R2 each condition lands in its own flag position
      for (int i = 0; i < 6; i++) begin
         vec_t v;
         v = '0;
         v.vld = 1'b1; v.exc = 6'(1 << i);
         v.e_sel = 6'(1 << i); v.e_sts = 16'(1 << i); v.e_ctl = 16'h003F;
         apply(v, 100 + i);
         v = '0;
         v.clr = 1'b1; v.e_ctl = 16'h003F;
         apply(v, 200 + i);
      end

      // R10 with everything unmasked: held irq falls one cycle after clear
      begin
         vec_t v;
         v = '0; v.wr = 1'b1; v.e_ctl = 16'h0000;
         apply(v, 300);
         v = '0; v.vld = 1'b1; v.exc = 6'h10; v.e_sts = 16'h0090; v.e_ctl = 16'h0000;
         apply(v, 301);
         v = '0; v.wt = 1'b1; v.e_sts = 16'h0090; v.e_ctl = 16'h0000; v.e_irq = 1'b1;
         apply(v, 302);
         v = '0; v.clr = 1'b1; v.e_ctl = 16'h0000; v.e_irq = 1'b1;
         apply(v, 303);
         v = '0; v.e_ctl = 16'h0000;
         apply(v, 304);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule